// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block produces the source and destination addresses for one DMA channel while the channel moves data. A descriptor is captured on a load strobe: for each of the two sides it carries a start address, an encoded element size, a signed step, a modulo window exponent and an adjustment applied once per completed major loop. A separate begin count gives the number of minor-loop iterations in one major loop.

The data mover pulses `xfer_done` after each element it moves and `minor_done` at the end of each minor loop. Each `xfer_done` steps both addresses by their own signed step. A modulo setting can confine that step to the low address bits. When a `minor_done` ends the final iteration, each side takes its end-of-loop adjustment instead of the step. The iteration counter reloads and `major_done` pulses for one cycle. Bus mastering, data storage, arbitration and descriptor fetch live elsewhere.

Top module: `dma_agen`

## Requirements
- R1: On `load`, both addresses take their start values and the iteration counter takes `begin_cnt`, all visible the cycle after. Reset clears both addresses to zero and holds `major_done` low.
- R2: On `xfer_done` (not load, not a final-iteration `minor_done`), each address adds its own sign-extended OFFW-bit step, independently per side.
- R3: In a cycle with none of `load`, `xfer_done` or `minor_done`, both addresses keep their values.
- R4: With a nonzero modulo exponent M, a step changes only address bits [M-1:0] and wraps within them; bits [AW-1:M] stay frozen. M = 0 means a full-width add.
- R5: The size code maps 0, 1, 2, 3 to 1, 2, 4, 8 bytes, shown on `src_bytes` and `dst_bytes` from the cycle after load.
- R6: Each `minor_done` lowers the iteration count by one. The `minor_done` that takes it to zero raises `major_done` for exactly the next cycle and reloads the count from the loaded begin count, so the next major loop is equally long.
- R7: On a final-iteration `minor_done`, each address adds its full-width end-of-loop adjustment, not confined by modulo. This replaces the step even if `xfer_done` is also high.
- R8: A `minor_done` on a non-final iteration leaves the addresses unchanged unless `xfer_done` is high too, in which case the normal step applies.
- R9: `load` in the same cycle as `xfer_done` or `minor_done` wins: the strobes have no effect and `major_done` stays low.
- R10: A begin count of zero behaves as one: the first `minor_done` completes the major loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Capture descriptor fields |
| src_start | input | AW | Source start address |
| src_size | input | 2 | Source element size code |
| src_step | input | OFFW | Signed source step |
| src_mod | input | MODW | Source modulo exponent (0 = off) |
| src_adj | input | AW | Source end-of-loop adjustment |
| dst_start | input | AW | Destination start address |
| dst_size | input | 2 | Destination element size code |
| dst_step | input | OFFW | Signed destination step |
| dst_mod | input | MODW | Destination modulo exponent (0 = off) |
| dst_adj | input | AW | Destination end-of-loop adjustment |
| begin_cnt | input | CNTW | Minor-loop iterations per major loop |
| xfer_done | input | 1 | One element moved |
| minor_done | input | 1 | Minor loop finished |
| src_addr | output | AW | Current source address |
| dst_addr | output | AW | Current destination address |
| src_bytes | output | 4 | Source element size in bytes |
| dst_bytes | output | 4 | Destination element size in bytes |
| major_done | output | 1 | One-cycle pulse at major-loop completion |

## Verification
The element step and the end-of-loop adjustment can fall in the same cycle. This happens when the last element of the final minor loop reports `xfer_done` together with `minor_done`. The bench drives both strobes in one cycle on the final iteration and expects each address to move by the adjustment alone, with `major_done` high the next cycle. The same pair on a non-final iteration is also driven, and there the step alone is expected. The bench also drives a load that coincides with both strobes, and expects the fresh start addresses with no completion pulse.

// File: rtl/dma_agen_pkg.sv
package dma_agen_pkg;

   typedef enum logic [1:0] {
      SZ_1B = 2'd0,
      SZ_2B = 2'd1,
      SZ_4B = 2'd2,
      SZ_8B = 2'd3
   } xfer_size_e;

   // Per-cycle action for one address side; priority is resolved in the top.
   typedef enum logic [1:0] {
      UPD_HOLD = 2'd0,
      UPD_LOAD = 2'd1,
      UPD_STEP = 2'd2,
      UPD_ADJ  = 2'd3
   } upd_e;

   function automatic logic [3:0] size_to_bytes(input xfer_size_e s);
      return 4'd1 << s;
   endfunction

endpackage

// File: rtl/dma_agen_iter.sv
module dma_agen_iter #(
   parameter int CNTW = 15
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [CNTW-1:0] begin_cnt,
   input  logic            minor_done,
   output logic            final_iter,
   output logic            major_done
);

   logic [CNTW-1:0] begin_q;
   logic [CNTW-1:0] cur_q;

   // A count of zero or one means the running iteration is the last one.
   assign final_iter = (cur_q <= CNTW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         begin_q    <= '0;
         cur_q      <= '0;
         major_done <= 1'b0;
      end else begin
         major_done <= 1'b0;
         if (load) begin
            begin_q <= begin_cnt;
            cur_q   <= begin_cnt;
         end else if (minor_done) begin
            if (final_iter) begin
               cur_q      <= begin_q;
               major_done <= 1'b1;
            end else begin
               cur_q <= cur_q - CNTW'(1);
            end
         end
      end
   end

endmodule

// File: rtl/dma_agen_side.sv
module dma_agen_side
   import dma_agen_pkg::*;
#(
   parameter int AW      = 32,
   parameter int OFFW    = 16,
   parameter int MODW    = 5,
   parameter bit USE_MOD = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  upd_e            upd,
   input  logic [AW-1:0]   start,
   input  logic [1:0]      size,
   input  logic [OFFW-1:0] step,
   input  logic [MODW-1:0] modx,
   input  logic [AW-1:0]   adj,
   output logic [AW-1:0]   addr,
   output logic [1:0]      size_q,
   output logic [MODW-1:0] mod_q,
   output logic [AW-1:0]   adj_q
);

   logic [OFFW-1:0] step_q;
   logic [AW-1:0]   step_ext;
   logic [AW-1:0]   sum;
   logic [AW-1:0]   stepped;

   assign step_ext = AW'(signed'(step_q));
   assign sum      = addr + step_ext;

   generate
      if (USE_MOD) begin : g_mod
         logic [AW-1:0] keep_low;
         assign keep_low = (mod_q == '0) ? {AW{1'b1}} : ~({AW{1'b1}} << mod_q);
         assign stepped  = (sum & keep_low) | (addr & ~keep_low);
      end else begin : g_flat
         assign stepped = sum;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr   <= '0;
         size_q <= '0;
         step_q <= '0;
         mod_q  <= '0;
         adj_q  <= '0;
      end else begin
         unique case (upd)
            UPD_LOAD: begin
               addr   <= start;
               size_q <= size;
               step_q <= step;
               mod_q  <= modx;
               adj_q  <= adj;
            end
            UPD_STEP: addr <= stepped;
            UPD_ADJ:  addr <= addr + adj_q;
            default:  ;
         endcase
      end
   end

endmodule

// File: rtl/dma_agen.sv
module dma_agen
   import dma_agen_pkg::*;
#(
   parameter int AW      = 32,
   parameter int OFFW    = 16,
   parameter int CNTW    = 15,
   parameter bit USE_MOD = 1'b1,
   localparam int MODW   = $clog2(AW)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [AW-1:0]   src_start,
   input  logic [1:0]      src_size,
   input  logic [OFFW-1:0] src_step,
   input  logic [MODW-1:0] src_mod,
   input  logic [AW-1:0]   src_adj,
   input  logic [AW-1:0]   dst_start,
   input  logic [1:0]      dst_size,
   input  logic [OFFW-1:0] dst_step,
   input  logic [MODW-1:0] dst_mod,
   input  logic [AW-1:0]   dst_adj,
   input  logic [CNTW-1:0] begin_cnt,
   input  logic            xfer_done,
   input  logic            minor_done,
   output logic [AW-1:0]   src_addr,
   output logic [AW-1:0]   dst_addr,
   output logic [3:0]      src_bytes,
   output logic [3:0]      dst_bytes,
   output logic            major_done
);

   localparam int NSIDE = 2;

   generate
      if (AW < 8 || AW > 64) begin : g_bad_aw
         $error("dma_agen: AW out of range");
      end
      if (OFFW < 2 || OFFW >= AW) begin : g_bad_offw
         $error("dma_agen: OFFW must be below AW");
      end
      if (CNTW < 2) begin : g_bad_cntw
         $error("dma_agen: CNTW too small");
      end
   endgenerate

   logic final_iter;
   upd_e upd;

   logic [AW-1:0]   start_a [NSIDE];
   logic [1:0]      size_a  [NSIDE];
   logic [OFFW-1:0] step_a  [NSIDE];
   logic [MODW-1:0] mod_a   [NSIDE];
   logic [AW-1:0]   adj_a   [NSIDE];
   logic [AW-1:0]   addr_a  [NSIDE];
   logic [1:0]      sizeq_a [NSIDE];
   logic [MODW-1:0] modq_a  [NSIDE];
   logic [AW-1:0]   adjq_a  [NSIDE];

   logic [MODW-1:0] src_mod_q;
   logic [AW-1:0]   src_adj_q;
   logic [AW-1:0]   dst_adj_q;

   assign start_a[0] = src_start;
   assign start_a[1] = dst_start;
   assign size_a[0]  = src_size;
   assign size_a[1]  = dst_size;
   assign step_a[0]  = src_step;
   assign step_a[1]  = dst_step;
   assign mod_a[0]   = src_mod;
   assign mod_a[1]   = dst_mod;
   assign adj_a[0]   = src_adj;
   assign adj_a[1]   = dst_adj;

   dma_agen_iter #(.CNTW(CNTW)) u_iter (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .begin_cnt  (begin_cnt),
      .minor_done (minor_done),
      .final_iter (final_iter),
      .major_done (major_done)
   );

   // Load beats completion, completion beats an element step.
   always_comb begin
      if (load)                          upd = UPD_LOAD;
      else if (minor_done && final_iter) upd = UPD_ADJ;
      else if (xfer_done)                upd = UPD_STEP;
      else                               upd = UPD_HOLD;
   end

   for (genvar g = 0; g < NSIDE; g++) begin : g_side
      dma_agen_side #(
         .AW(AW), .OFFW(OFFW), .MODW(MODW), .USE_MOD(USE_MOD)
      ) u_side (
         .clk    (clk),
         .rst_n  (rst_n),
         .upd    (upd),
         .start  (start_a[g]),
         .size   (size_a[g]),
         .step   (step_a[g]),
         .modx   (mod_a[g]),
         .adj    (adj_a[g]),
         .addr   (addr_a[g]),
         .size_q (sizeq_a[g]),
         .mod_q  (modq_a[g]),
         .adj_q  (adjq_a[g])
      );
   end

   assign src_addr  = addr_a[0];
   assign dst_addr  = addr_a[1];
   assign src_bytes = size_to_bytes(xfer_size_e'(sizeq_a[0]));
   assign dst_bytes = size_to_bytes(xfer_size_e'(sizeq_a[1]));
   assign src_mod_q = modq_a[0];
   assign src_adj_q = adjq_a[0];
   assign dst_adj_q = adjq_a[1];

endmodule

// File: rtl/dma_agen_chk.sv
module dma_agen_chk #(
   parameter int AW   = 32,
   parameter int MODW = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic            load,
   input logic            xfer_done,
   input logic            minor_done,
   input logic [AW-1:0]   src_start,
   input logic [AW-1:0]   dst_start,
   input logic [AW-1:0]   src_addr,
   input logic [AW-1:0]   dst_addr,
   input logic            major_done,
   input logic [MODW-1:0] src_mod_q,
   input logic [AW-1:0]   src_adj_q,
   input logic [AW-1:0]   dst_adj_q
);

   a_r1_load_start: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (src_addr == $past(src_start)) && (dst_addr == $past(dst_start)));

   a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !xfer_done && !minor_done) |=> $stable(src_addr) && $stable(dst_addr));

   a_r4_mod_upper_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && xfer_done && !minor_done && src_mod_q != '0)
      |=> ((src_addr ^ $past(src_addr)) >> $past(src_mod_q)) == '0);

   a_r6_major_cause: assert property (@(posedge clk) disable iff (!rst_n)
      major_done |-> $past(minor_done) && !$past(load));

   a_r7_adjust_applied: assert property (@(posedge clk) disable iff (!rst_n)
      major_done |-> (src_addr == $past(src_addr + src_adj_q))
                  && (dst_addr == $past(dst_addr + dst_adj_q)));

   a_r9_load_no_major: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !major_done);

endmodule

bind dma_agen dma_agen_chk #(.AW(AW), .MODW(MODW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .load       (load),
   .xfer_done  (xfer_done),
   .minor_done (minor_done),
   .src_start  (src_start),
   .dst_start  (dst_start),
   .src_addr   (src_addr),
   .dst_addr   (dst_addr),
   .major_done (major_done),
   .src_mod_q  (src_mod_q),
   .src_adj_q  (src_adj_q),
   .dst_adj_q  (dst_adj_q)
);

// File: tb/dma_agen_tb_top.sv
`timescale 1ns/1ps
module dma_agen_tb_top;

   localparam int AW = 32, OFFW = 16, CNTW = 15, MODW = 5;

   typedef struct {
      logic [31:0] src;
      logic [31:0] dst;
      logic        maj;
      logic [3:0]  sb;
      logic [3:0]  db;
      string       tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic load = 1'b0, xfer_done = 1'b0, minor_done = 1'b0;
   logic [AW-1:0]   src_start = '0, dst_start = '0, src_adj = '0, dst_adj = '0;
   logic [1:0]      src_size = '0, dst_size = '0;
   logic [OFFW-1:0] src_step = '0, dst_step = '0;
   logic [MODW-1:0] src_mod = '0, dst_mod = '0;
   logic [CNTW-1:0] begin_cnt = '0;
   logic [AW-1:0]   src_addr, dst_addr;
   logic [3:0]      src_bytes, dst_bytes;
   logic            major_done;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   exp_t exp_q[$];
   exp_t got;

   // bench model state
   logic [31:0] m_src = 0, m_dst = 0, m_sadj = 0, m_dadj = 0;
   logic [15:0] m_sstep = 0, m_dstep = 0;
   logic [4:0]  m_smod = 0, m_dmod = 0;
   logic [3:0]  m_sb = 1, m_db = 1;
   int          m_iter = 0, m_begin = 0;

   always #10 clk = ~clk;

   dma_agen dut_i (
      .clk(clk), .rst_n(rst_n), .load(load),
      .src_start(src_start), .src_size(src_size), .src_step(src_step),
      .src_mod(src_mod), .src_adj(src_adj),
      .dst_start(dst_start), .dst_size(dst_size), .dst_step(dst_step),
      .dst_mod(dst_mod), .dst_adj(dst_adj),
      .begin_cnt(begin_cnt), .xfer_done(xfer_done), .minor_done(minor_done),
      .src_addr(src_addr), .dst_addr(dst_addr),
      .src_bytes(src_bytes), .dst_bytes(dst_bytes), .major_done(major_done)
   );

   function automatic logic [31:0] wrap_step(input logic [31:0] cur,
                                             input logic [15:0] st,
                                             input logic [4:0] m);
      logic [31:0] nxt;
      nxt = cur + {{16{st[15]}}, st};
      if (m == 0) return nxt;
      return ((cur >> m) << m) | (nxt % (32'd1 << m));
   endfunction

   function automatic logic [3:0] bytes_of(input logic [1:0] code);
      case (code)
         2'd0: return 4'd1;
         2'd1: return 4'd2;
         2'd2: return 4'd4;
         default: return 4'd8;
      endcase
   endfunction

   task automatic drive(input bit ld, input bit xd, input bit md, input string tag);
      exp_t e;
      bit maj;
      @(negedge clk);
      load = ld; xfer_done = xd; minor_done = md;
      maj = 1'b0;
      if (ld) begin
         m_src = src_start; m_dst = dst_start;
         m_sstep = src_step; m_dstep = dst_step;
         m_smod = src_mod; m_dmod = dst_mod;
         m_sadj = src_adj; m_dadj = dst_adj;
         m_sb = bytes_of(src_size); m_db = bytes_of(dst_size);
         m_begin = begin_cnt; m_iter = begin_cnt;
      end else if (md && m_iter <= 1) begin
         maj = 1'b1;
         m_src = m_src + m_sadj;
         m_dst = m_dst + m_dadj;
         m_iter = m_begin;
      end else begin
         if (xd) begin
            m_src = wrap_step(m_src, m_sstep, m_smod);
            m_dst = wrap_step(m_dst, m_dstep, m_dmod);
         end
         if (md) m_iter = m_iter - 1;
      end
      e.src = m_src; e.dst = m_dst; e.maj = maj;
      e.sb = m_sb; e.db = m_db; e.tag = tag;
      exp_q.push_back(e);
      @(posedge clk);
      #1;
      load = 1'b0; xfer_done = 1'b0; minor_done = 1'b0;
   endtask

   // monitor / scoreboard
   always @(posedge clk) begin
      #5;
      if (exp_q.size() > 0) begin
         got = exp_q.pop_front();
         checks++;
         if (src_addr !== got.src || dst_addr !== got.dst || major_done !== got.maj
             || src_bytes !== got.sb || dst_bytes !== got.db) begin
            failures++;
            $display("FAIL %s: got src=%h dst=%h maj=%b sb=%0d db=%0d exp src=%h dst=%h maj=%b sb=%0d db=%0d",
                     got.tag, src_addr, dst_addr, major_done, src_bytes, dst_bytes,
                     got.src, got.dst, got.maj, got.sb, got.db);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: got hang exp completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1 reset state
      checks++;
      if (src_addr !== '0 || dst_addr !== '0 || major_done !== 1'b0) begin
         failures++;
         $display("FAIL R1 reset: got src=%h dst=%h maj=%b exp 0 0 0", src_addr, dst_addr, major_done);
      end
      rst_n = 1'b1;

      // Descriptor A: source steps +4, destination steps -1, two iterations
      src_start = 32'h0000_1000; src_size = 2'd2; src_step = 16'd4;
      src_mod = 5'd0; src_adj = 32'hFFFF_FFF0;
      dst_start = 32'h0000_2000; dst_size = 2'd0; dst_step = 16'hFFFF;
      dst_mod = 5'd0; dst_adj = 32'h0000_0004;
      begin_cnt = 15'd2;
      drive(1, 0, 0, "R1 R5 load A");
      drive(0, 0, 0, "R3 idle hold");
      for (int i = 0; i < 3; i++) drive(0, 1, 0, "R2 element step");
      drive(0, 1, 1, "R8 minor with step, non-final");
      for (int i = 0; i < 3; i++) drive(0, 1, 0, "R2 element step");
      drive(0, 1, 1, "R7 adjust replaces step on final");
      drive(0, 0, 0, "R6 pulse ends");
      drive(0, 0, 1, "R8 minor alone, non-final");
      drive(0, 0, 1, "R6 reloaded loop completes");

      // Descriptor B: modulo windows on both sides, begin count zero
      src_start = 32'h0000_10F8; src_size = 2'd3; src_step = 16'd4;
      src_mod = 5'd4; src_adj = 32'h0000_0100;
      dst_start = 32'h4000_0010; dst_size = 2'd1; dst_step = 16'hFFE0;
      dst_mod = 5'd8; dst_adj = 32'h0000_0100;
      begin_cnt = 15'd0;
      drive(1, 0, 0, "R5 load B sizes 8 and 2");
      for (int i = 0; i < 4; i++) drive(0, 1, 0, "R4 modulo wrap");
      drive(0, 0, 1, "R10 zero begin completes at once");
      drive(0, 1, 0, "R4 step after adjust");

      // Descriptor C: load coincides with both strobes
      src_start = 32'h0000_8000; src_size = 2'd1; src_step = 16'd2;
      src_mod = 5'd0; src_adj = 32'h0000_0000;
      dst_start = 32'h0000_9000; dst_size = 2'd3; dst_step = 16'd8;
      dst_mod = 5'd0; dst_adj = 32'hFFFF_FFF8;
      begin_cnt = 15'd1;
      drive(1, 1, 1, "R9 load wins over strobes");
      drive(0, 1, 0, "R9 step after load");
      drive(0, 1, 1, "R6 R7 single iteration completes");

      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule